// File: doc/BRIEF.md
# Staged Word-Memory Access Unit

This block connects a processing datapath to a synchronous word memory. The datapath never touches the memory directly. Every access passes through two staging registers. The address register (`mar`) holds the location being accessed. The data register (`mdr`) holds the word being moved in either direction. The memory itself sits inside the block as a parameterized register array, written so that a block RAM can be inferred.

A client raises `req_valid` together with an operation bit, an address and, for a store, a data word. Once the request is accepted, a small sequencer walks through a fixed order of one-cycle steps, and that order differs between loads and stores:

- **Load:** capture the address, pulse the read strobe, then present the fetched word in the data register.
- **Store:** capture the data word, capture the address, then pulse the write strobe.

The unit reports `busy` for the length of the sequence and a one-cycle `done` when it ends. A request that arrives while a sequence is running is dropped; it is not queued.

Top module: `mem_xfer_bridge`

## Requirements
- R1: While reset is high, and in the cycle after it, `mar` and `mdr` read zero, `mem_rd`, `mem_wr`, `busy` and `done` are low, and `req_ready` is high.
- R2: A request is accepted at a rising edge where `req_valid` and `req_ready` are both high, with `req_op` 0 meaning load and 1 meaning store. From that edge, `busy` is high and `req_ready` is low for exactly two cycles.
- R3: For a load, `mar` equals the request address in the cycle after acceptance.
- R4: For a load, `mem_rd` is high for exactly the one cycle after acceptance, and `mem_wr` stays low throughout.
- R5: For a load, the word stored at the address appears on `mdr` in the third cycle after acceptance, the same cycle that `done` is high.
- R6: For a store, `mdr` equals the write data and `mar` is unchanged in the cycle after acceptance. `mar` equals the request address one cycle later.
- R7: For a store, `mem_wr` is high for exactly the second cycle after acceptance, with `mem_rd` low. The word is then returned by any later load of that address.
- R8: `done` is high for exactly one cycle, three cycles after acceptance, and `busy` is low in that cycle.
- R9: A request presented while `busy` is high is ignored. It does not change `mar`, `mdr` or memory, and it produces no later `done`.
- R10: A new request presented in the `done` cycle is accepted at the next edge, so back-to-back accesses run with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client request strobe |
| req_op | input | 1 | 0 = load, 1 = store |
| req_addr | input | ADDR_W | Word address of the access |
| req_wdata | input | DATA_W | Word to write on a store |
| req_ready | output | 1 | High when a request can be accepted |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mar | output | ADDR_W | Address staging register |
| mdr | output | DATA_W | Data staging register; holds the loaded word after a load |

## Verification
Take the edge that accepts a request as edge zero. Every result of the unit falls due at a fixed edge after it:

- the first staging capture and the leading strobe state settle after edge zero;
- the second capture and the write strobe settle after edge one;
- `done`, together with the loaded word on `mdr`, settles after edge two.

The driver samples the step results on the falling edge that follows each of those rising edges. A scoreboard monitor pops one expected item for every `done` it sees on a falling edge and checks the staging registers against it. A `done` that finds the queue empty shows that a request made while busy was wrongly taken.

// File: rtl/mxb_pkg.sv
package mxb_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_LD_READ = 3'd1,
    SQ_LD_CAPT = 3'd2,
    SQ_ST_ADDR = 3'd3,
    SQ_ST_WRIT = 3'd4
  } mxb_step_e;

  localparam logic OP_LOAD  = 1'b0;
  localparam logic OP_STORE = 1'b1;

endpackage

// File: rtl/mxb_sequencer.sv
module mxb_sequencer
  import mxb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_op,
  output logic take_req_addr,
  output logic take_req_data,
  output logic take_hold_addr,
  output logic take_ram_word,
  output logic busy,
  output logic done,
  output logic rd_stb,
  output logic wr_stb
);

  mxb_step_e step_q, step_d;
  logic      accept;

  assign accept = req_valid && !busy;

  always_comb begin
    step_d         = step_q;
    take_req_addr  = 1'b0;
    take_req_data  = 1'b0;
    take_hold_addr = 1'b0;
    take_ram_word  = 1'b0;
    case (step_q)
      SQ_IDLE: begin
        if (accept) begin
          if (req_op == OP_STORE) begin
            take_req_data = 1'b1;
            step_d        = SQ_ST_ADDR;
          end else begin
            take_req_addr = 1'b1;
            step_d        = SQ_LD_READ;
          end
        end
      end
      SQ_LD_READ: step_d = SQ_LD_CAPT;
      SQ_LD_CAPT: begin
        take_ram_word = 1'b1;
        step_d        = SQ_IDLE;
      end
      SQ_ST_ADDR: begin
        take_hold_addr = 1'b1;
        step_d         = SQ_ST_WRIT;
      end
      SQ_ST_WRIT: step_d = SQ_IDLE;
      default:    step_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= SQ_IDLE;
      busy   <= 1'b0;
      done   <= 1'b0;
      rd_stb <= 1'b0;
      wr_stb <= 1'b0;
    end else begin
      step_q <= step_d;
      busy   <= (step_d != SQ_IDLE);
      done   <= (step_q == SQ_LD_CAPT) || (step_q == SQ_ST_WRIT);
      rd_stb <= (step_d == SQ_LD_READ);
      wr_stb <= (step_d == SQ_ST_WRIT);
    end
  end

endmodule

// File: rtl/mxb_staging.sv
module mxb_staging #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_req_addr,
  input  logic              take_req_data,
  input  logic              take_hold_addr,
  input  logic              take_ram_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] ram_word,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mdr
);

  logic [ADDR_W-1:0] addr_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      mar       <= '0;
      mdr       <= '0;
      addr_hold <= '0;
    end else begin
      if (take_req_addr)       mar <= req_addr;
      else if (take_hold_addr) mar <= addr_hold;

      if (take_req_data)      mdr <= req_wdata;
      else if (take_ram_word) mdr <= ram_word;

      if (take_req_data) addr_hold <= req_addr;
    end
  end

endmodule

// File: rtl/mxb_ram.sv
module mxb_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[addr] <= wdata;
    if (rd_en) rdata <= cells[addr];
  end

endmodule

// File: rtl/mem_xfer_bridge.sv
module mem_xfer_bridge #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              busy,
  output logic              done,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mdr
);

  logic              take_req_addr;
  logic              take_req_data;
  logic              take_hold_addr;
  logic              take_ram_word;
  logic [DATA_W-1:0] ram_word;

  mxb_sequencer u_seq (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_op         (req_op),
    .take_req_addr  (take_req_addr),
    .take_req_data  (take_req_data),
    .take_hold_addr (take_hold_addr),
    .take_ram_word  (take_ram_word),
    .busy           (busy),
    .done           (done),
    .rd_stb         (mem_rd),
    .wr_stb         (mem_wr)
  );

  mxb_staging #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
    .clk            (clk),
    .rst            (rst),
    .take_req_addr  (take_req_addr),
    .take_req_data  (take_req_data),
    .take_hold_addr (take_hold_addr),
    .take_ram_word  (take_ram_word),
    .req_addr       (req_addr),
    .req_wdata      (req_wdata),
    .ram_word       (ram_word),
    .mar            (mar),
    .mdr            (mdr)
  );

  mxb_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .rd_en (mem_rd),
    .wr_en (mem_wr),
    .addr  (mar),
    .wdata (mdr),
    .rdata (ram_word)
  );

  assign req_ready = !busy;

endmodule

// File: rtl/mxb_checker.sv
module mxb_checker #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              req_ready,
  input logic              busy,
  input logic              done,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mar,
  input logic [DATA_W-1:0] mdr
);

  // R3
  load_addr_staged_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_op) |=> (busy && mem_rd && mar == $past(req_addr)));

  // R6
  store_data_staged_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_op) |=> (busy && !mem_wr && mdr == $past(req_wdata) && $stable(mar)));

  // R4
  read_strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> (!mem_rd && !mem_wr && busy));

  // R5
  load_finish_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> ##1 done);

  // R7
  write_finish_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> (done && !mem_wr && $stable(mar) && $stable(mdr)));

  // R7
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !mem_rd && !mem_wr) ##1 !done);

  // R9
  busy_holds_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && mem_rd) |=> $stable(mar));

endmodule

bind mem_xfer_bridge mxb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .req_ready (req_ready),
  .busy      (busy),
  .done      (done),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mar       (mar),
  .mdr       (mdr)
);

// File: tb/mem_xfer_bridge_test.sv
module mem_xfer_bridge_test;

  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_op = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, busy, done, mem_rd, mem_wr;
  logic [AW-1:0] mar;
  logic [DW-1:0] mdr;

  mem_xfer_bridge #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .busy(busy), .done(done), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mar(mar), .mdr(mdr)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic          op;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } exp_item_t;

  exp_item_t     sb_q[$];
  logic [DW-1:0] shadow [1 << AW];
  int            n_chk = 0;
  int            n_bad = 0;
  logic          prev_done = 1'b0;
  bit            finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (done && prev_done) check(1'b0, "R8", "done wider than one cycle", 32'd1, 32'd0);
      if (done) begin
        check(!busy, "R8", "busy during done", 32'(busy), 32'd0);
        if (sb_q.size() == 0) begin
          check(1'b0, "R9", "completion with no accepted request", 32'd1, 32'd0);
        end else begin
          exp_item_t it;
          it = sb_q.pop_front();
          if (it.op == 1'b0) begin
            check(mdr == it.data, "R5", "loaded word on mdr", 32'(mdr), 32'(it.data));
          end else begin
            check(mar == it.addr, "R7", "store address at done", 32'(mar), 32'(it.addr));
            check(mdr == it.data, "R7", "store data at done", 32'(mdr), 32'(it.data));
          end
        end
      end
    end
    prev_done = done;
  end

  // driver: called at a negedge; returns at the negedge after done rises
  task automatic xfer(input logic op, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                      input bit intrude, input logic [AW-1:0] ia, input logic [DW-1:0] id);
    exp_item_t     it;
    logic [AW-1:0] mar_before;
    while (!req_ready) @(negedge clk);
    mar_before = mar;
    req_valid  = 1'b1;
    req_op     = op;
    req_addr   = a;
    req_wdata  = wd;
    it.op   = op;
    it.addr = a;
    it.data = op ? wd : shadow[a];
    sb_q.push_back(it);
    if (op) shadow[a] = wd;
    @(negedge clk);
    if (intrude) begin
      req_valid = 1'b1; req_op = 1'b1; req_addr = ia; req_wdata = id;
    end else begin
      req_valid = 1'b0;
    end
    check(busy && !req_ready, "R2", "busy after accept", 32'(busy), 32'd1);
    if (!op) begin
      check(mar == a, "R3", "mar after load accept", 32'(mar), 32'(a));
      check(mem_rd && !mem_wr, "R4", "read strobe first step", 32'(mem_rd), 32'd1);
    end else begin
      check(mdr == wd, "R6", "mdr after store accept", 32'(mdr), 32'(wd));
      check(mar == mar_before, "R6", "mar held first step", 32'(mar), 32'(mar_before));
      check(!mem_wr && !mem_rd, "R7", "no strobe first step", 32'(mem_wr), 32'd0);
    end
    @(negedge clk);
    check(busy && !req_ready, "R2", "busy second step", 32'(busy), 32'd1);
    if (!op) begin
      check(!mem_rd && !mem_wr, "R4", "read strobe dropped", 32'(mem_rd), 32'd0);
      check(mar == a, "R9", "mar stable during load", 32'(mar), 32'(a));
    end else begin
      check(mar == a, "R6", "mar after second step", 32'(mar), 32'(a));
      check(mem_wr && !mem_rd, "R7", "write strobe second step", 32'(mem_wr), 32'd1);
      if (intrude) check(mdr == wd, "R9", "mdr kept during store", 32'(mdr), 32'(wd));
    end
    @(negedge clk);
    req_valid = 1'b0;
    check(done, "R8", "done third cycle", 32'(done), 32'd1);
    check(!busy && req_ready, "R2", "busy released", 32'(busy), 32'd0);
    check(!mem_rd && !mem_wr, "R8", "strobes idle at done", 32'(mem_wr), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(mar == '0 && mdr == '0, "R1", "staging cleared", 32'(mar), 32'd0);
    check(!mem_rd && !mem_wr && !busy && !done && req_ready, "R1", "control idle",
          32'({mem_rd, mem_wr, busy, done, req_ready}), 32'd1);
    rst = 1'b0;
    @(negedge clk);
    check(mar == '0 && mdr == '0 && !busy && !done, "R1", "state after release", 32'(mdr), 32'd0);

    // basic stores then loads, distinct patterns and boundary addresses
    xfer(1'b1, 8'h00, 16'hFFFF, 1'b0, '0, '0);
    xfer(1'b1, 8'hFF, 16'hA5A5, 1'b0, '0, '0);
    xfer(1'b1, 8'h55, 16'h0000, 1'b0, '0, '0);
    xfer(1'b0, 8'h00, '0, 1'b0, '0, '0);
    xfer(1'b0, 8'hFF, '0, 1'b0, '0, '0);
    xfer(1'b0, 8'h55, '0, 1'b0, '0, '0);
    // R10: back-to-back store then load of the same word, overwrite
    xfer(1'b1, 8'h55, 16'h1234, 1'b0, '0, '0);
    xfer(1'b0, 8'h55, '0, 1'b0, '0, '0);
    // R9: requests during busy ignored
    xfer(1'b0, 8'hFF, '0, 1'b1, 8'h00, 16'hDEAD);
    xfer(1'b1, 8'h10, 16'h0F0F, 1'b1, 8'hFF, 16'hBEEF);
    xfer(1'b0, 8'h00, '0, 1'b0, '0, '0);
    xfer(1'b0, 8'hFF, '0, 1'b0, '0, '0);
    xfer(1'b0, 8'h10, '0, 1'b0, '0, '0);
    // sweep
    for (int i = 0; i < 16; i++)
      xfer(1'b1, AW'(i * 17 + 3), DW'(16'h3C00 ^ (i * 16'h0101)), 1'b0, '0, '0);
    for (int i = 15; i >= 0; i--)
      xfer(1'b0, AW'(i * 17 + 3), '0, 1'b0, '0, '0);
    repeat (4) @(negedge clk);
    check(sb_q.size() == 0, "R9", "scoreboard drained", 32'(sb_q.size()), 32'd0);
    check(!done && !busy, "R9", "no stray completion", 32'(done), 32'd0);
    finished = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

endmodule